// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block sits at the input of a raster display controller. A memory reader delivers 32-bit words with a valid/ready handshake. The block breaks each word into two 16-bit halves and, under a 2-bit load-mode field latched when the controller is enabled, sends those halves either into a 256 x 12-bit colour lookup RAM or on toward the pixel output as frame data.

The first palette half is a header. Its upper nibble selects the pixel format, and its lower twelve bits are palette entry 0. In indexed mode each frame half carries two 8-bit indices, and each index is turned into 12-bit RGB through the lookup RAM. In direct mode each frame half is an RGB565 pixel, cut down to 4 bits per channel. Pixels are pulled one at a time by a request from the display timing side. A request that finds no data is reported as an underflow. A sticky status flag marks the end of a palette load.

Top module: `lcdpl_loader`

## Requirements
- R1: After reset, and whenever `ctrl_en` is low, `pal_loaded`, `pix_valid`, `underflow` and `in_ready` are all 0.
- R2: Each accepted 32-bit word is consumed as two 16-bit halves, bits 15:0 first and then bits 31:16.
- R3: On the cycle `ctrl_en` rises, `load_mode` is latched with these codes: 2'b01 loads the palette only, 2'b10 loads frame data only, 2'b00 loads the palette and then the frame. With 2'b01, and with the unused code 2'b11, a pixel request produces neither a pixel nor an underflow.
- R4: Bits 15:12 of the first palette half are the format code. 4'h3 selects 8-bit indexed pixels, and any other value selects 16-bit direct pixels. Bits 11:0 of that half are palette entry 0.
- R5: A palette load consumes the entry count plus two halves: 256 entries in indexed format, 16 in direct format. That is 129 or 9 input words. Halves after the last entry are discarded. Entry i is bits 11:0 of half i, with red in 11:8, green in 7:4 and blue in 3:0.
- R6: `pal_loaded` goes high on the clock edge that consumes the final palette half. It does not go high before that edge.
- R7: `clear_sw` clears `pal_loaded` only when the latched mode is palette-only. In the other modes the flag holds until `ctrl_en` goes low, and `ctrl_en` low always clears it.
- R8: In indexed format a frame half yields two pixels, bits 7:0 first and then bits 15:8. Each pixel's `pix_rgb` is the addressed palette entry, and `pix_valid` is high on the cycle after the request.
- R9: In direct format each frame half yields one pixel: `pix_rgb` = {d[15:12], d[10:7], d[4:1]}, with `pix_valid` high on the cycle after the request.
- R10: A pixel request during the frame phase with no half available gives `underflow` high for one cycle on the next cycle, with `pix_valid` low.
- R11: The format code is kept while the controller is disabled, so a frame-only load uses the format set by the most recent palette header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; rising edge starts a load, low aborts and clears |
| load_mode | input | 2 | Load selection, latched when `ctrl_en` rises |
| clear_sw | input | 1 | Software clear of the loaded flag |
| in_valid | input | 1 | Reader word valid |
| in_data | input | 32 | Reader word |
| in_ready | output | 1 | Block accepts `in_data` this cycle |
| pix_req | input | 1 | Request for one pixel |
| pix_valid | output | 1 | `pix_rgb` holds a pixel |
| pix_rgb | output | 12 | Pixel colour {R,G,B} at 4 bits each |
| underflow | output | 1 | One-cycle pulse: request found no data |
| pal_loaded | output | 1 | Palette load complete (sticky) |

## Verification
A pixel answers its request on the next cycle. `pix_valid`, `pix_rgb` and `underflow` all come from registers loaded at the edge that samples `pix_req`. For this reason the bench raises the request at a falling edge and reads all three outputs at the following falling edge. The loaded flag changes at the edge that takes the last palette half, and that edge comes two edges after the final word is accepted. The bench therefore waits three edges before it checks the flag, and makes the same check one word short to confirm the flag has not risen early. `in_ready` is sampled just after each falling edge, and the word counts as taken at the next rising edge only when that sample was high.

// File: rtl/lcdpl_pkg.sv
package lcdpl_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int IDX_W  = HALF_W / 2;
  localparam int RGB_W  = 12;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_INDEXED = 4'h3;
  localparam logic [CODE_W-1:0] CODE_DIRECT  = 4'h4;

  localparam logic [1:0] LM_BOTH  = 2'b00;
  localparam logic [1:0] LM_PAL   = 2'b01;
  localparam logic [1:0] LM_FRAME = 2'b10;
  localparam logic [1:0] LM_RSVD  = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_PAL, ST_FRAME, ST_HOLD} seq_state_e;

  function automatic logic is_indexed(input logic [CODE_W-1:0] code);
    return code == CODE_INDEXED;
  endfunction

  function automatic logic [RGB_W-1:0] rgb565_to_444(input logic [HALF_W-1:0] d);
    return {d[15:12], d[10:7], d[4:1]};
  endfunction
endpackage

// File: rtl/lcdpl_half_split.sv
module lcdpl_half_split
  import lcdpl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              half_valid,
  output logic [HALF_W-1:0] half_data,
  input  logic              half_take
);
  logic [WORD_W-1:0] word_q;
  logic              full_q;
  logic              upper_q;
  logic              load;

  assign half_valid = full_q;
  assign half_data  = upper_q ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
  assign in_ready   = !flush && (!full_q || (half_take && upper_q));
  assign load       = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      full_q  <= 1'b0;
      upper_q <= 1'b0;
    end else if (flush) begin
      full_q  <= 1'b0;
      upper_q <= 1'b0;
    end else if (load) begin
      word_q  <= in_data;
      full_q  <= 1'b1;
      upper_q <= 1'b0;
    end else if (half_take) begin
      if (upper_q) begin
        full_q  <= 1'b0;
        upper_q <= 1'b0;
      end else begin
        upper_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdpl_lut_ram.sv
module lcdpl_lut_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lcdpl_ctrl.sv
module lcdpl_ctrl
  import lcdpl_pkg::*;
#(
  parameter int DIRECT_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [1:0]        load_mode,
  input  logic              clear_sw,
  input  logic              half_valid,
  input  logic [HALF_W-1:0] half_data,
  input  logic              pix_req,
  output logic              half_take,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [RGB_W-1:0]  wr_data,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              dir_en,
  output logic              underflow_ev,
  output logic              pal_done_ev,
  output logic              mode_pal_only,
  output logic              pal_loaded
);
  localparam int IDX_ENTRIES = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IDX_ENTRIES + 1);
  localparam logic [CNT_W-1:0] LAST_DIR = CNT_W'(DIRECT_ENTRIES + 1);

  seq_state_e        state_q;
  logic [1:0]        mode_q;
  logic [CODE_W-1:0] fmt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              byte_hi_q;
  logic              loaded_q;

  logic              hdr_half;
  logic [CODE_W-1:0] code_now;
  logic [CNT_W-1:0]  pal_last;
  logic              pal_take;
  logic              pix_go;
  logic              fmt_idx;

  always_comb begin
    hdr_half     = (cnt_q == '0);
    code_now     = hdr_half ? half_data[HALF_W-1 -: CODE_W] : fmt_q;
    pal_last     = is_indexed(code_now) ? LAST_IDX : LAST_DIR;
    pal_take     = (state_q == ST_PAL) && half_valid;
    pal_done_ev  = pal_take && (cnt_q == pal_last);
    wr_en        = pal_take && (cnt_q != pal_last) && (cnt_q != pal_last - 1'b1);
    wr_addr      = cnt_q[IDX_W-1:0];
    wr_data      = half_data[RGB_W-1:0];
    fmt_idx      = is_indexed(fmt_q);
    pix_go       = (state_q == ST_FRAME) && pix_req && half_valid;
    underflow_ev = (state_q == ST_FRAME) && pix_req && !half_valid;
    rd_en        = pix_go && fmt_idx;
    dir_en       = pix_go && !fmt_idx;
    rd_idx       = byte_hi_q ? half_data[HALF_W-1:IDX_W] : half_data[IDX_W-1:0];
    half_take    = pal_take || dir_en || (rd_en && byte_hi_q);
    mode_pal_only = (mode_q == LM_PAL);
  end

  assign pal_loaded = loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= LM_BOTH;
      fmt_q     <= CODE_DIRECT;
      cnt_q     <= '0;
      byte_hi_q <= 1'b0;
      loaded_q  <= 1'b0;
    end else if (!ctrl_en) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      byte_hi_q <= 1'b0;
      loaded_q  <= 1'b0;
    end else begin
      if (clear_sw && mode_pal_only) loaded_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          mode_q    <= load_mode;
          cnt_q     <= '0;
          byte_hi_q <= 1'b0;
          if (load_mode == LM_FRAME)     state_q <= ST_FRAME;
          else if (load_mode == LM_RSVD) state_q <= ST_HOLD;
          else                           state_q <= ST_PAL;
        end
        ST_PAL: begin
          if (pal_take) begin
            if (hdr_half) fmt_q <= half_data[HALF_W-1 -: CODE_W];
            cnt_q <= cnt_q + 1'b1;
            if (pal_done_ev) begin
              loaded_q  <= 1'b1;
              byte_hi_q <= 1'b0;
              state_q   <= (mode_q == LM_BOTH) ? ST_FRAME : ST_HOLD;
            end
          end
        end
        ST_FRAME: begin
          if (rd_en) byte_hi_q <= !byte_hi_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcdpl_loader.sv
module lcdpl_loader
  import lcdpl_pkg::*;
#(
  parameter int DIRECT_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [1:0]        load_mode,
  input  logic              clear_sw,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pix_req,
  output logic              pix_valid,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              underflow,
  output logic              pal_loaded
);
  logic              half_valid;
  logic [HALF_W-1:0] half_data;
  logic              half_take;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [RGB_W-1:0]  wr_data;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic              dir_en;
  logic              underflow_ev;
  logic              pal_done_ev;
  logic              mode_pal_only;
  logic [RGB_W-1:0]  lut_q;
  logic [RGB_W-1:0]  dir_q;
  logic              sel_lut_q;
  logic              valid_q;
  logic              uf_q;

  lcdpl_half_split split_i (
    .clk(clk), .rst_n(rst_n), .flush(!ctrl_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .half_valid(half_valid), .half_data(half_data), .half_take(half_take)
  );

  lcdpl_ctrl #(.DIRECT_ENTRIES(DIRECT_ENTRIES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .load_mode(load_mode),
    .clear_sw(clear_sw), .half_valid(half_valid), .half_data(half_data),
    .pix_req(pix_req), .half_take(half_take), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .dir_en(dir_en), .underflow_ev(underflow_ev), .pal_done_ev(pal_done_ev),
    .mode_pal_only(mode_pal_only), .pal_loaded(pal_loaded)
  );

  lcdpl_lut_ram #(.ADDR_W(IDX_W), .DATA_W(RGB_W)) lut_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_idx), .rd_data(lut_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      sel_lut_q <= 1'b0;
      valid_q   <= 1'b0;
      uf_q      <= 1'b0;
    end else begin
      valid_q <= (rd_en || dir_en) && ctrl_en;
      uf_q    <= underflow_ev && ctrl_en;
      if (rd_en || dir_en) sel_lut_q <= rd_en;
      if (dir_en) dir_q <= rgb565_to_444(half_data);
    end
  end

  assign pix_valid = valid_q;
  assign underflow = uf_q;
  assign pix_rgb   = sel_lut_q ? lut_q : dir_q;
endmodule

// File: rtl/lcdpl_loader_chk.sv
module lcdpl_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_en,
  input logic clear_sw,
  input logic pix_req,
  input logic pix_valid,
  input logic underflow,
  input logic pal_loaded,
  input logic in_ready,
  input logic pal_done_ev,
  input logic mode_pal_only
);
  AST_NO_READY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !in_ready); // R1
  AST_UNDERFLOW_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && underflow)); // R10
  AST_PIXEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pix_req)); // R8
  AST_LOADED_RISE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_loaded) |-> $past(pal_done_ev)); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !pal_loaded); // R7
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_loaded && ctrl_en && !(clear_sw && mode_pal_only)) |=> pal_loaded); // R7
endmodule

bind lcdpl_loader lcdpl_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .clear_sw(clear_sw),
  .pix_req(pix_req), .pix_valid(pix_valid), .underflow(underflow),
  .pal_loaded(pal_loaded), .in_ready(in_ready), .pal_done_ev(pal_done_ev),
  .mode_pal_only(mode_pal_only)
);

// File: tb/lcdpl_loader_tb.sv
`timescale 1ns/1ps
module lcdpl_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic [1:0]  load_mode = 2'b00;
  logic        clear_sw = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        pix_req = 1'b0;
  logic        pix_valid;
  logic [11:0] pix_rgb;
  logic        underflow;
  logic        pal_loaded;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lcdpl_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .load_mode(load_mode),
    .clear_sw(clear_sw), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pix_req(pix_req), .pix_valid(pix_valid),
    .pix_rgb(pix_rgb), .underflow(underflow), .pal_loaded(pal_loaded)
  );

  // Direct-format vectors: RGB565 half and expected 12-bit colour (R9)
  localparam logic [15:0] VEC_IN  [8] = '{16'hFFFF, 16'h0000, 16'hF800, 16'h07E0,
                                          16'h001F, 16'h8410, 16'h0821, 16'h1234};
  localparam logic [11:0] VEC_EXP [8] = '{12'hFFF, 12'h000, 12'hF00, 12'h0F0,
                                          12'h00F, 12'h888, 12'h000, 12'h14A};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pcol(input int i);
    return 12'((i * 109 + 23) & 12'hFFF);
  endfunction

  function automatic logic [15:0] idx_half(input int k);
    if (k == 0)   return {4'h3, pcol(0)};
    if (k < 256)  return {4'hA, pcol(k)};
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] dir_half(input int k);
    if (k == 0)  return 16'h4ABC;
    if (k < 16)  return 16'h5555;
    return 16'hDEAD;
  endfunction

  task automatic push(input logic [31:0] w);
    logic rdy;
    rdy = 1'b0;
    while (!rdy) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      #1 rdy = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pull(input string tag, input logic ev, input logic [11:0] erg, input logic euf);
    @(negedge clk);
    pix_req = 1'b1;
    @(negedge clk);
    pix_req = 1'b0;
    check({tag, " valid"}, pix_valid, ev);
    check({tag, " underflow"}, underflow, euf);
    if (ev) check({tag, " rgb"}, pix_rgb, erg);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enable(input logic [1:0] m);
    @(negedge clk);
    load_mode = m;
    ctrl_en = 1'b1;
  endtask

  task automatic disable_ctrl();
    @(negedge clk);
    ctrl_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 loaded", pal_loaded, 0);
    check("R1 valid", pix_valid, 0);
    check("R1 underflow", underflow, 0);
    check("R1 in_ready", in_ready, 0);

    // Table walk first: palette-then-frame, direct header 4'h4 (R3 R4 R5)
    enable(2'b00);
    for (int w = 0; w < 9; w++) push({dir_half(2*w+1), dir_half(2*w)});
    wait_cyc(3);
    check("R6 loaded after direct palette", pal_loaded, 1);
    @(negedge clk); clear_sw = 1'b1;
    @(negedge clk); clear_sw = 1'b0;
    check("R7 sw clear ignored in mode 00", pal_loaded, 1);
    for (int v = 0; v < 8; v += 2) begin
      push({VEC_IN[v+1], VEC_IN[v]});
      pull("R9 R2 low half", 1'b1, VEC_EXP[v], 1'b0);
      pull("R9 R2 high half", 1'b1, VEC_EXP[v+1], 1'b0);
    end
    pull("R10 direct empty", 1'b0, 12'h0, 1'b1);
    disable_ctrl();
    check("R7 disable clears", pal_loaded, 0);
    check("R1 ready low when disabled", in_ready, 0);

    // Palette-only, indexed header 4'h3
    enable(2'b01);
    for (int w = 0; w < 128; w++) push({idx_half(2*w+1), idx_half(2*w)});
    wait_cyc(3);
    check("R5 R6 not loaded one word short", pal_loaded, 0);
    push({idx_half(257), idx_half(256)});
    wait_cyc(3);
    check("R6 loaded after indexed palette", pal_loaded, 1);
    pull("R3 palette-only no pixel", 1'b0, 12'h0, 1'b0);
    @(negedge clk); clear_sw = 1'b1;
    @(negedge clk); clear_sw = 1'b0;
    check("R7 sw clear in palette-only", pal_loaded, 0);
    disable_ctrl();

    // Frame-only, format retained as indexed
    enable(2'b10);
    pull("R10 indexed empty", 1'b0, 12'h0, 1'b1);
    push(32'hFF80_0100);
    pull("R8 R4 idx 00 header entry", 1'b1, pcol(0), 1'b0);
    pull("R8 R11 idx 01", 1'b1, pcol(1), 1'b0);
    pull("R8 R2 idx 80", 1'b1, pcol(128), 1'b0);
    pull("R8 idx FF", 1'b1, pcol(255), 1'b0);
    push(32'h1234_5678);
    pull("R8 idx 78", 1'b1, pcol(8'h78), 1'b0);
    pull("R8 idx 56", 1'b1, pcol(8'h56), 1'b0);
    pull("R8 idx 34", 1'b1, pcol(8'h34), 1'b0);
    pull("R8 idx 12", 1'b1, pcol(8'h12), 1'b0);
    check("R3 frame-only no loaded flag", pal_loaded, 0);
    disable_ctrl();

    // Reserved mode 11: nothing happens
    enable(2'b11);
    push(32'h0000_3000);
    pull("R3 reserved mode", 1'b0, 12'h0, 1'b0);
    wait_cyc(2);
    check("R3 reserved loaded", pal_loaded, 0);
    disable_ctrl();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule